// File: doc/BRIEF.md
# Multi-mode timer capture unit

This block copies the value of a free-running 16-bit timer into a capture register when a chosen event occurs on one asynchronous input pin. A 4-bit mode field selects the event: a falling edge, a rising edge, every fourth rising edge or every sixteenth rising edge. The other codes of the field belong to compare and PWM functions that live outside this block. For those codes the unit does not capture.

Each capture raises an interrupt flag. The flag stays set until software pulses the clear strobe. The all-zero mode code switches the unit off. It empties the capture register, drops the flag and clears the edge prescaler.

The timer, the interrupt controller and the register decoding that drives the mode field are outside the block. The pin passes through a two-flop synchronizer, and edges are found by comparing successive synchronized samples.

Top module: `tmr_capture_unit`

## Requirements
- R1: With mode 4'b0100, every falling edge of `pin_in` causes a capture, and a rising edge does not.
- R2: With mode 4'b0101, every rising edge of `pin_in` causes a capture.
- R3: With mode 4'b0110, a capture happens on every 4th rising edge, so three rising edges give no capture.
- R4: With mode 4'b0111, a capture happens on every 16th rising edge, so fifteen rising edges give no capture.
- R5: A level change on `pin_in` first sampled at clock edge k loads `cap_value` and sets `cap_flag` at clock edge k+2. The loaded value is `timer_val` as sampled at that edge.
- R6: `cap_flag` sets in the same cycle that `cap_value` loads and stays set until `flag_clr` is high at a clock edge. If a capture and `flag_clr` arrive at the same edge, the flag ends up set.
- R7: While mode is 4'b0000, `cap_value` is 0, `cap_flag` is 0 and the prescale count is cleared. The next prescaled capture then needs a full 4 or 16 rising edges.
- R8: Any change of the mode field clears the prescale count, so the first capture after a change needs a full 4 or 16 rising edges.
- R9: Mode codes other than 4'b0000 and 4'b0100 to 4'b0111 never capture and leave `cap_value` and `cap_flag` unchanged.
- R10: A synchronous active-high `rst` sets `cap_value` to 0 and `cap_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| timer_val | input | 16 | Free-running timer value to be captured |
| pin_in | input | 1 | Asynchronous event input |
| mode | input | 4 | Mode select field |
| flag_clr | input | 1 | Strobe that clears the capture flag |
| cap_value | output | 16 | Capture register |
| cap_flag | output | 1 | Capture interrupt flag |

## Verification
The hardest situation to reach from the ports is a capture and a flag clear landing on the same clock edge. The capture edge sits two clocks behind the pin change because of the synchronizer. The stimulus therefore raises the pin, counts two rising clock edges, and only then raises `flag_clr` for exactly the capture edge.

A stale prescale count is also hard to see from outside. To expose one, the bench first leaves part of a count behind. It then changes the mode, or passes through the off code, and shows that a short run of edges no longer completes a capture.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF   = 4'b0000,
    MD_FALL  = 4'b0100,
    MD_RISE  = 4'b0101,
    MD_DIV_A = 4'b0110,
    MD_DIV_B = 4'b0111
  } tcu_mode_e;
endpackage

// File: rtl/tcu_pin_edge.sv
module tcu_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur  = sync_q[SYNC_STAGES-1];
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  generate
    if (SYNC_STAGES == 2) begin : g_chk
      // A detected rise must come from a pin level seen two edges back
      p_rise_origin_r5: assert property (@(posedge clk) disable iff (rst)
        rise |-> $past(pin_raw, 2));
      p_fall_origin_r5: assert property (@(posedge clk) disable iff (rst)
        fall |-> !$past(pin_raw, 2));
    end
  endgenerate
endmodule

// File: rtl/tcu_prescale.sv
module tcu_prescale
  import tcu_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              rise,
  input  logic              fall,
  output logic              hit
);
  localparam int CNT_W = $clog2(DIV_B > DIV_A ? DIV_B : DIV_A);

  logic [CNT_W-1:0]  cnt_q;
  logic [MODE_W-1:0] mode_q;
  logic              mode_chg;
  logic              is_off;
  logic              divided;
  logic [CNT_W-1:0]  last;

  assign mode_chg = (mode != mode_q);
  assign is_off   = (mode == MD_OFF);

  always_comb begin
    divided = 1'b0;
    last    = '0;
    case (mode)
      MD_DIV_A: begin divided = 1'b1; last = CNT_W'(DIV_A - 1); end
      MD_DIV_B: begin divided = 1'b1; last = CNT_W'(DIV_B - 1); end
      default:  ;
    endcase
  end

  always_comb begin
    hit = 1'b0;
    if (!mode_chg) begin
      case (mode)
        MD_FALL:  hit = fall;
        MD_RISE:  hit = rise;
        MD_DIV_A,
        MD_DIV_B: hit = rise && (cnt_q == last);
        default:  hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= MD_OFF;
    end else begin
      mode_q <= mode;
      if (is_off || mode_chg)
        cnt_q <= '0;
      else if (divided && rise)
        cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end
  end

  p_mode_change_clears_r8: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (cnt_q == '0));
  p_off_clears_count_r7: assert property (@(posedge clk) disable iff (rst)
    is_off |=> (cnt_q == '0));
  p_no_hit_off_r9: assert property (@(posedge clk) disable iff (rst)
    (mode[3] || is_off) |-> !hit);
endmodule

// File: rtl/tcu_store.sv
module tcu_store #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             off,
  input  logic             load,
  input  logic             clr,
  input  logic [VAL_W-1:0] tval,
  output logic [VAL_W-1:0] value,
  output logic             flag
);
  always_ff @(posedge clk) begin
    if (rst || off) begin
      value <= '0;
      flag  <= 1'b0;
    end else begin
      if (load)
        value <= tval;
      if (load)
        flag <= 1'b1;
      else if (clr)
        flag <= 1'b0;
    end
  end

  p_load_sets_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (load && !off) |=> (flag && value == $past(tval)));
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr && !off) |=> flag);
  p_value_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && !off) |=> $stable(value));
  p_off_clears_r7: assert property (@(posedge clk) disable iff (rst)
    off |=> (value == '0 && !flag));
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcu_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TMR_W-1:0]  timer_val,
  input  logic              pin_in,
  input  logic [MODE_W-1:0] mode,
  input  logic              flag_clr,
  output logic [TMR_W-1:0]  cap_value,
  output logic              cap_flag
);
  logic rise;
  logic fall;
  logic hit;
  logic off;

  assign off = (mode == MD_OFF);

  tcu_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .pin_raw (pin_in),
    .rise    (rise),
    .fall    (fall)
  );

  tcu_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .rise (rise),
    .fall (fall),
    .hit  (hit)
  );

  tcu_store #(.VAL_W(TMR_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .off   (off),
    .load  (hit),
    .clr   (flag_clr),
    .tval  (timer_val),
    .value (cap_value),
    .flag  (cap_flag)
  );

  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (cap_value == '0 && !cap_flag));
endmodule

// File: tb/tmr_capture_unit_bench.sv
module tmr_capture_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  // {mode[3:0], pulses[5:0], timer[15:0], exp_flag, exp_value[15:0]}
  localparam logic [42:0] VEC [NVEC] = '{
    {4'b0100, 6'd1,  16'h1234, 1'b1, 16'h1234},  // R1 falling edge
    {4'b0101, 6'd1,  16'hA5A5, 1'b1, 16'hA5A5},  // R2 single rise
    {4'b0101, 6'd3,  16'h0F0F, 1'b1, 16'h0F0F},  // R2 several rises
    {4'b0110, 6'd3,  16'h1111, 1'b0, 16'h0000},  // R3 three is short
    {4'b0110, 6'd4,  16'h2222, 1'b1, 16'h2222},  // R3 fourth edge
    {4'b0111, 6'd15, 16'h3333, 1'b0, 16'h0000},  // R4 fifteen is short
    {4'b0111, 6'd16, 16'h4444, 1'b1, 16'h4444},  // R4 sixteenth edge
    {4'b1000, 6'd2,  16'h5555, 1'b0, 16'h0000},  // R9 compare code
    {4'b1100, 6'd2,  16'h6666, 1'b0, 16'h0000}   // R9 pwm code
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] timer_val = '0;
  logic        pin_in = 1'b0;
  logic [3:0]  mode = 4'b0000;
  logic        flag_clr = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_capture_unit u_tmr_capture_unit (
    .clk       (clk),
    .rst       (rst),
    .timer_val (timer_val),
    .pin_in    (pin_in),
    .mode      (mode),
    .flag_clr  (flag_clr),
    .cap_value (cap_value),
    .cap_flag  (cap_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin_in = 1'b1; cyc(3);
      pin_in = 1'b0; cyc(3);
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode = m; cyc(2);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 value", cap_value, 0);
    chk("R10 flag", cap_flag, 0);

    for (int v = 0; v < NVEC; v++) begin
      set_mode(4'b0000);
      set_mode(VEC[v][42:39]);
      timer_val = VEC[v][32:17];
      pulses(int'(VEC[v][38:33]));
      cyc(2);
      chk($sformatf("vec%0d flag", v), cap_flag, VEC[v][16]);
      chk($sformatf("vec%0d value", v), cap_value, VEC[v][15:0]);
    end

    // R1: a rising edge alone does not capture in falling mode
    set_mode(4'b0000);
    set_mode(4'b0100);
    timer_val = 16'h7777;
    pin_in = 1'b1; cyc(5);
    chk("R1 no capture on rise", cap_flag, 0);
    pin_in = 1'b0; cyc(4);
    chk("R1 capture on fall", cap_value, 16'h7777);

    // R5: exact latency, value taken at the load edge
    set_mode(4'b0000);
    set_mode(4'b0101);
    timer_val = 16'h0100;
    pin_in = 1'b1;
    @(posedge clk); @(negedge clk);           // edge k
    chk("R5 flag after k", cap_flag, 0);
    timer_val = 16'h0200;
    @(posedge clk); @(negedge clk);           // edge k+1
    chk("R5 flag after k+1", cap_flag, 0);
    timer_val = 16'h0300;
    @(posedge clk); @(negedge clk);           // edge k+2
    chk("R5 flag after k+2", cap_flag, 1);
    chk("R5 value at k+2", cap_value, 16'h0300);
    pin_in = 1'b0; cyc(3);

    // R6: clear strobe drops the flag and keeps the value
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R6 cleared", cap_flag, 0);
    chk("R6 value kept", cap_value, 16'h0300);

    // R6: capture and clear on the same edge, set wins
    timer_val = 16'h0404;
    pin_in = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    flag_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    flag_clr = 1'b0;
    chk("R6 set wins", cap_flag, 1);
    chk("R6 set wins value", cap_value, 16'h0404);
    pin_in = 1'b0; cyc(3);

    // R9: non-capture code keeps value and flag
    timer_val = 16'hBEEF; pulses(1); cyc(2);
    chk("R9 setup", cap_value, 16'hBEEF);
    set_mode(4'b1010);
    timer_val = 16'h1357; pulses(2); cyc(2);
    chk("R9 value kept", cap_value, 16'hBEEF);
    chk("R9 flag kept", cap_flag, 1);

    // R7: off code clears everything
    set_mode(4'b0000);
    chk("R7 value cleared", cap_value, 0);
    chk("R7 flag cleared", cap_flag, 0);

    // R8: mode change discards a partial count
    set_mode(4'b0110);
    timer_val = 16'h2468;
    pulses(2);
    set_mode(4'b0111);
    set_mode(4'b0110);
    pulses(3); cyc(2);
    chk("R8 partial count dropped", cap_flag, 0);
    pulses(1); cyc(2);
    chk("R8 full count captures", cap_flag, 1);
    chk("R8 value", cap_value, 16'h2468);

    // R7: off code also discards a partial count
    set_mode(4'b0000);
    set_mode(4'b0110);
    pulses(3);
    set_mode(4'b0000);
    set_mode(4'b0110);
    pulses(1); cyc(2);
    chk("R7 count cleared by off", cap_flag, 0);

    // R10: reset in mid-operation
    set_mode(4'b0101);
    timer_val = 16'h9999; pulses(1); cyc(2);
    rst = 1'b1; cyc(2); rst = 1'b0; @(negedge clk);
    chk("R10 value after reset", cap_value, 0);
    chk("R10 flag after reset", cap_flag, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule